// File: doc/BRIEF.md
# Split-Wire Host to Four-Bus Open-Drain I2C Selector

This block joins a host I2C master to one of four downstream open-drain I2C buses: an SFP cage, a mezzanine card, and two optical transceiver modules (A and B). The host is not open-drain. Its SDA arrives as a separate input wire and returns on a separate output wire. Its SCL comes in on an input wire only. Two host GPIO inputs form a 2-bit code that names the target bus.

On the device side, every SDA and SCL line is represented by a pull-low enable. When the enable is 1, the line is driven to 0. When it is 0, the line is released and an external pull-up raises it. Each device SDA line also has a read-back input, which carries the level actually present on the wire.

Only the selected bus follows the host's low levels. The SDA wire returned to the host is the wired-AND of all four read-backs. Two active-low module-select pins tell the optical modules when they are the target. The selection is registered, and it changes only while the host holds both SCL and SDA high, so a transfer that is under way is never redirected to another bus.

Top module: `i2c3w_mux`

## Requirements
- R1: Bus codes: 0 selects the SFP bus (lane 0), 1 the mezzanine bus (lane 1), 2 optical module A (lane 2), 3 optical module B (lane 3). Lane k uses bit k of each device vector.
- R2: The SDA pull-low enable of a lane is 1 only when that lane is the active bus and host SDA-in is 0. In every other case it is 0 (released).
- R3: The SCL pull-low enable of a lane is 1 only when that lane is the active bus and host SCL-in is 0. In every other case it is 0.
- R4: Host SDA-out equals the AND of all four device SDA read-back inputs, with no clock delay.
- R5: The requested code is built from two separate host inputs: `host_sel0_i` is bit 0 and `host_sel1_i` is bit 1.
- R6: `opt_sel_n_o[0]` is 0 exactly when the active code is 2. `opt_sel_n_o[1]` is 0 exactly when the active code is 3. Otherwise both are 1.
- R7: At a rising clock edge where host SCL-in and SDA-in are both 1, the requested code becomes the active code, visible right after that edge. At any other edge the active code is held.
- R8: A synchronous active-high reset sets the active code to 0 (SFP), whatever the select inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| host_sel0_i | input | 1 | Requested bus code, bit 0 |
| host_sel1_i | input | 1 | Requested bus code, bit 1 |
| host_scl_i | input | 1 | Host SCL level |
| host_sda_i | input | 1 | Host SDA level (low = host pulls) |
| host_sda_o | output | 1 | Wired-AND of device SDA lines back to host |
| dev_scl_pull_o | output | 4 | Per-bus SCL pull-low enable |
| dev_sda_pull_o | output | 4 | Per-bus SDA pull-low enable |
| dev_sda_rd_i | input | 4 | Per-bus SDA wire level read back |
| opt_sel_n_o | output | 2 | Active-low select for optical modules A and B |

## Verification
The bench changes the select code while SCL is low, while only SDA is low, and while only SCL is low. In each case the active bus must stay put. A design that samples the select bits without the idle qualifier would move the pulls to a different lane in the middle of a transfer. The bench pulls a single read-back low on buses that are not selected, to confirm that the return path is a true AND over all four lines and not a mux of the selected line. It also applies a reset while code 3 is active, with a nonzero request present on the select inputs, to confirm that reset falls back to the SFP bus and that both module selects go high.

// File: rtl/i2cmux_pkg.sv
package i2cmux_pkg;

    localparam int NUM_BUS = 4;
    localparam int CODE_W  = $clog2(NUM_BUS);
    localparam int NUM_OPT = 2;

    typedef enum logic [CODE_W-1:0] {
        BUS_SFP  = 2'd0,
        BUS_MEZZ = 2'd1,
        BUS_OPTA = 2'd2,
        BUS_OPTB = 2'd3
    } bus_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } host_line_t;

    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
    } lane_drive_t;

    // Both host lines high: no bit or start/stop in progress.
    function automatic logic host_idle(host_line_t h);
        return h.scl & h.sda;
    endfunction

    // Optical module index -> bus code it answers to.
    function automatic bus_e opt_code(int idx);
        return (idx == 0) ? BUS_OPTA : BUS_OPTB;
    endfunction

endpackage

// File: rtl/i2cmux_sel_hold.sv
module i2cmux_sel_hold
    import i2cmux_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [CODE_W-1:0] req_code_i,
    input  host_line_t host_i,
    output bus_e       active_o
);
    bus_e active_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            active_q <= BUS_SFP;
        end else if (host_idle(host_i)) begin
            active_q <= bus_e'(req_code_i);
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/i2cmux_lane.sv
module i2cmux_lane
    import i2cmux_pkg::*;
#(
    parameter int LANE_CODE = 0
) (
    input  bus_e        active_i,
    input  host_line_t  host_i,
    output lane_drive_t drive_o
);
    logic hit;

    always_comb begin
        hit              = (active_i == bus_e'(LANE_CODE));
        drive_o.sda_pull = hit & ~host_i.sda;
        drive_o.scl_pull = hit & ~host_i.scl;
    end
endmodule

// File: rtl/i2cmux_ret_and.sv
module i2cmux_ret_and
    import i2cmux_pkg::*;
(
    input  logic [NUM_BUS-1:0] rd_i,
    output logic               sda_o
);
    assign sda_o = &rd_i;
endmodule

// File: rtl/i2c3w_mux.sv
module i2c3w_mux
    import i2cmux_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               host_sel0_i,
    input  logic               host_sel1_i,
    input  logic               host_scl_i,
    input  logic               host_sda_i,
    output logic               host_sda_o,
    output logic [NUM_BUS-1:0] dev_scl_pull_o,
    output logic [NUM_BUS-1:0] dev_sda_pull_o,
    input  logic [NUM_BUS-1:0] dev_sda_rd_i,
    output logic [NUM_OPT-1:0] opt_sel_n_o
);
    host_line_t        host;
    logic [CODE_W-1:0] req_code;
    bus_e              active;

    assign host.scl = host_scl_i;
    assign host.sda = host_sda_i;
    assign req_code = {host_sel1_i, host_sel0_i};

    i2cmux_sel_hold u_sel (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .req_code_i (req_code),
        .host_i     (host),
        .active_o   (active)
    );

    for (genvar k = 0; k < NUM_BUS; k++) begin : g_lane
        lane_drive_t drv;
        i2cmux_lane #(.LANE_CODE(k)) u_lane (
            .active_i (active),
            .host_i   (host),
            .drive_o  (drv)
        );
        assign dev_sda_pull_o[k] = drv.sda_pull;
        assign dev_scl_pull_o[k] = drv.scl_pull;
    end

    for (genvar m = 0; m < NUM_OPT; m++) begin : g_opt
        assign opt_sel_n_o[m] = (active != opt_code(m));
    end

    i2cmux_ret_and u_ret (
        .rd_i  (dev_sda_rd_i),
        .sda_o (host_sda_o)
    );
endmodule

// File: rtl/i2c3w_mux_chk.sv
module i2c3w_mux_chk
    import i2cmux_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic               host_scl_i,
    input logic               host_sda_i,
    input logic [NUM_BUS-1:0] dev_scl_pull_o,
    input logic [NUM_BUS-1:0] dev_sda_pull_o,
    input logic [NUM_OPT-1:0] opt_sel_n_o
);
    // R2: at most one SDA lane pulls, and none while host SDA is high
    p_sda_onehot_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(dev_sda_pull_o));
    p_sda_release_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        host_sda_i |-> (dev_sda_pull_o == '0));
    // R3
    p_scl_onehot_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(dev_scl_pull_o));
    p_scl_release_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        host_scl_i |-> (dev_scl_pull_o == '0));
    // R6: never both modules selected; selected module's lane carries host pulls
    p_opt_exclusive_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !(opt_sel_n_o[0] == 1'b0 && opt_sel_n_o[1] == 1'b0));
    p_opt_lane_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!opt_sel_n_o[1] && !host_sda_i) |-> dev_sda_pull_o[3]);
    // R7: a busy host line holds the selection across the next edge
    p_hold_busy_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !(host_scl_i && host_sda_i) |=> $stable(opt_sel_n_o));
endmodule

bind i2c3w_mux i2c3w_mux_chk u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .host_scl_i     (host_scl_i),
    .host_sda_i     (host_sda_i),
    .dev_scl_pull_o (dev_scl_pull_o),
    .dev_sda_pull_o (dev_sda_pull_o),
    .opt_sel_n_o    (opt_sel_n_o)
);

// File: tb/tb_i2c3w_mux.sv
module tb_i2c3w_mux;
    logic       clk = 1'b0;
    logic       rst;
    logic       sel0, sel1, scl, sda;
    logic       hsda_o;
    logic [3:0] scl_pull, sda_pull, rd;
    logic [1:0] opt_n;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    i2c3w_mux dut (
        .clk_i(clk), .rst_i(rst), .host_sel0_i(sel0), .host_sel1_i(sel1),
        .host_scl_i(scl), .host_sda_i(sda), .host_sda_o(hsda_o),
        .dev_scl_pull_o(scl_pull), .dev_sda_pull_o(sda_pull),
        .dev_sda_rd_i(rd), .opt_sel_n_o(opt_n)
    );

    // {sel[1:0], scl, sda, rd[3:0], expected active code[1:0]}
    localparam logic [9:0] VEC [12] = '{
        {2'd1, 1'b1, 1'b1, 4'hF, 2'd1},  // R7 adopt code 1 when idle
        {2'd1, 1'b0, 1'b0, 4'hF, 2'd1},  // R2 R3 lane 1 pulls
        {2'd3, 1'b0, 1'b0, 4'hF, 2'd1},  // R7 change while busy ignored
        {2'd3, 1'b1, 1'b0, 4'hF, 2'd1},  // R7 SDA low only: hold
        {2'd3, 1'b0, 1'b1, 4'hF, 2'd1},  // R7 SCL low only: hold
        {2'd3, 1'b1, 1'b1, 4'hF, 2'd3},  // R7 adopt 3
        {2'd3, 1'b1, 1'b0, 4'hE, 2'd3},  // R4 unselected lane 0 low
        {2'd2, 1'b1, 1'b1, 4'h7, 2'd2},  // R5 only bit1 set; R4
        {2'd2, 1'b0, 1'b1, 4'hF, 2'd2},  // R3 SCL pull lane 2
        {2'd0, 1'b1, 1'b1, 4'hF, 2'd0},  // R1 back to SFP
        {2'd0, 1'b0, 1'b0, 4'hB, 2'd0},  // R2 lane 0, R4 lane 2 low
        {2'd2, 1'b1, 1'b1, 4'hF, 2'd2}   // R6 module A select
    };

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected outputs from the requirements, for an active code c
    task automatic check_all(logic [1:0] c);
        logic [3:0] lane = 4'b0001 << c;
        chk("R2", sda_pull, sda ? 4'h0 : lane);
        chk("R3", scl_pull, scl ? 4'h0 : lane);
        chk("R4", {3'b0, hsda_o}, {3'b0, &rd});
        chk("R6", {2'b0, opt_n}, {2'b0, (c != 2'd3), (c != 2'd2)});
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; {sel1, sel0} = 2'd3; scl = 1'b1; sda = 1'b0; rd = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check_all(2'd0);  // R8 reset state is SFP despite request 3
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            {sel1, sel0, scl, sda, rd} = VEC[i][9:2];
            @(posedge clk); #1;
            check_all(VEC[i][1:0]);  // R1 R5 R7 via code
        end

        // R7: move to 3 then hold over a long busy stretch with changing request
        @(negedge clk); {sel1, sel0} = 2'd3; scl = 1'b1; sda = 1'b1;
        @(posedge clk); #1; check_all(2'd3);
        @(negedge clk); scl = 1'b0; sda = 1'b0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk); {sel1, sel0} = 2'(j);
            @(posedge clk); #1; check_all(2'd3);
        end

        // R8: reset mid-use with request 1 pending returns to SFP
        @(negedge clk); rst = 1'b1; {sel1, sel0} = 2'd1; scl = 1'b1; sda = 1'b1;
        @(posedge clk); #1; check_all(2'd0);
        @(negedge clk); rst = 1'b0; sda = 1'b0;
        @(posedge clk); #1; check_all(2'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule